// File: doc/BRIEF.md
# Packed-Lane Booth Fraction Multiplier

This block multiplies two floating-point fractions and returns the product in carry-save form. The final carry-propagate addition, normalisation, exponent arithmetic and rounding happen downstream. The multiplier is recoded into radix-4 Booth digits. For a 56-bit unsigned operand, 29 partial products and one row of negation corrections are reduced by a chain of 3:2 compressors. The result is a 116-bit sum vector and a 116-bit carry vector.

The block has two operating modes, selected per operation. In wide mode a single pair of 56-bit fractions, which already include their implicit bit, is multiplied. This width also holds a 14-digit hexadecimal fraction. In packed mode each 64-bit operand bus carries two single-precision lanes. The caller places each lane's implicit bit directly above its 23-bit fraction, so each lane is 24 bits. The block clears the sign and exponent positions of both halves. It also gates off the partial products that would mix the two lanes, so the upper-lane product and the lower-lane product come out at fixed, non-overlapping bit positions of one shared array.

There are two register stages: one after Booth recoding and one after compression. The latency is therefore a fixed two cycles, and the block accepts a new operation every cycle.

Top module: `simd_frac_mul`

## Requirements
- R1: In wide mode (`pack_mode`=0), (`sum_o` + `carry_o`) mod 2^116 equals `op_a[55:0]` × `op_b[55:0]` exactly, and bits 63:56 of either bus have no effect on the result.
- R2: In packed mode (`pack_mode`=1), the upper lane of each bus is bits 55:32 and the lower lane is bits 23:0. Bits 63:56 and 31:24 of both buses have no effect. (`sum_o` + `carry_o`) mod 2^116 equals upper_a×upper_b×2^64 + lower_a×lower_b.
- R3: In packed mode, bits 47:0 of the resolved sum hold the lower-lane product, bits 111:64 hold the upper-lane product, and bits 63:48 are zero.
- R4: In either mode, bits 115:112 of the resolved sum are zero.
- R5: `out_valid` is high exactly two rising clock edges after an edge at which `in_valid` was high, and low two edges after an edge at which it was low.
- R6: Operations may be issued on consecutive cycles with the mode changing on every operation, and each result is exact for its own operands and mode.
- R7: While `rst_n` is low, and after its release until an operation has been issued, `out_valid` is low.
- R8: When no operation completes at an edge, `sum_o` and `carry_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| pack_mode | input | 1 | 0: one 56-bit product, 1: two 24-bit lane products |
| op_a | input | 64 | Multiplicand operand bus |
| op_b | input | 64 | Multiplier operand bus (Booth recoded) |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| sum_o | output | 116 | Carry-save sum vector |
| carry_o | output | 116 | Carry-save carry vector |

## Verification
The checker verifies the following on every cycle that has a valid result: the modular sum of the two vectors matches the exact product of the operands issued two cycles before, in the mode they were issued with. It also verifies that the bits above the 112-bit product are zero, that the guard bits between the lanes are zero in packed mode, and that the valid strobe follows issue with two cycles of delay in both directions. The bench scenarios cover the remaining behaviour. They show that the result holds during idle cycles, that the valid strobe is low during and after reset, and that the ignored sign and exponent bits really do not matter. They also exercise the corner operands: zero, all ones, and an implicit bit alone, including Booth carry digits out of the top of each lane.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  // One radix-4 Booth digit: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } sfm_digit_t;

endpackage

// File: rtl/sfm_operand_fmt.sv
module sfm_operand_fmt #(
  parameter int BUS_W  = 64,
  parameter int FRAC_W = 56,
  parameter int HALF_W = 32,
  parameter int LANE_W = 24
) (
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              pk_i,
  output logic [FRAC_W-1:0] frac_o
);

  localparam logic [BUS_W-1:0] LANE_ONES = {{(BUS_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
  localparam logic [BUS_W-1:0] WIDE_MASK = {{(BUS_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};
  localparam logic [BUS_W-1:0] PACK_MASK = LANE_ONES | (LANE_ONES << HALF_W);

  logic [BUS_W-1:0] kept;

  // packed mode clears sign/exponent positions of both halves
  assign kept   = bus_i & (pk_i ? PACK_MASK : WIDE_MASK);
  assign frac_o = kept[FRAC_W-1:0];

endmodule

// File: rtl/sfm_booth_recode.sv
module sfm_booth_recode
  import sfm_pkg::*;
#(
  parameter int FRAC_W = 56,
  parameter int NDIG   = FRAC_W/2 + 1
) (
  input  logic [FRAC_W-1:0]        mult_i,
  output sfm_digit_t [NDIG-1:0]    dig_o
);

  localparam int EXT_W = 2*NDIG + 1;

  logic [EXT_W-1:0] ext;

  // zero below bit 0 and zero-extended above: unsigned operand
  assign ext = EXT_W'({mult_i, 1'b0});

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    logic hi, mid, lo;
    assign hi  = ext[2*j+2];
    assign mid = ext[2*j+1];
    assign lo  = ext[2*j];
    assign dig_o[j] = '{neg: hi & ~(mid & lo),
                        one: mid ^ lo,
                        two: (hi & ~mid & ~lo) | (~hi & mid & lo)};
  end

endmodule

// File: rtl/sfm_ppgen.sv
module sfm_ppgen
  import sfm_pkg::*;
#(
  parameter int FRAC_W = 56,
  parameter int HALF_W = 32,
  parameter int NDIG   = FRAC_W/2 + 1,
  parameter int PROD_W = 2*FRAC_W + 4,
  parameter int NROW   = NDIG + 1
) (
  input  logic [FRAC_W-1:0]              mcand_i,
  input  sfm_digit_t [NDIG-1:0]          dig_i,
  input  logic                           pk_i,
  output logic [NROW-1:0][PROD_W-1:0]    rows_o
);

  // digits below LO_DIG weight the lower lane, the rest the upper lane
  localparam int LO_DIG = HALF_W/2;
  localparam logic [FRAC_W-1:0] LO_MASK = {{(FRAC_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  for (genvar j = 0; j < NDIG; j++) begin : g_row
    logic [FRAC_W-1:0] mc;
    logic [PROD_W-1:0] mag;

    if (j < LO_DIG) begin : g_lo
      assign mc = pk_i ? (mcand_i & LO_MASK) : mcand_i;
    end else begin : g_hi
      assign mc = pk_i ? (mcand_i & ~LO_MASK) : mcand_i;
    end

    assign mag = dig_i[j].two ? (PROD_W'(mc) << 1) :
                 dig_i[j].one ?  PROD_W'(mc)       : '0;

    // negative digit: ones' complement here, +1 at bit 2j in the correction row
    assign rows_o[j] = (dig_i[j].neg ? ~mag : mag) << (2*j);
  end

  logic [PROD_W-1:0] corr;

  always_comb begin
    corr = '0;
    for (int j = 0; j < NDIG; j++) begin
      corr[2*j] = dig_i[j].neg;
    end
  end

  assign rows_o[NDIG] = corr;

endmodule

// File: rtl/sfm_csa3.sv
module sfm_csa3 #(
  parameter int W = 116
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);

  logic [W-1:0] maj;

  assign s_o = x_i ^ y_i ^ z_i;
  assign maj = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign c_o = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/simd_frac_mul.sv
module simd_frac_mul
  import sfm_pkg::*;
#(
  parameter int BUS_W  = 64,
  parameter int FRAC_W = 56,
  parameter int HALF_W = 32,
  parameter int LANE_W = 24,
  parameter int PROD_W = 2*FRAC_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              pack_mode,
  input  logic [BUS_W-1:0]  op_a,
  input  logic [BUS_W-1:0]  op_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] sum_o,
  output logic [PROD_W-1:0] carry_o
);

  localparam int NDIG = FRAC_W/2 + 1;
  localparam int NROW = NDIG + 1;
  localparam int NCSA = NROW - 2;

  // ---------------- operand conditioning and recoding ----------------
  logic [FRAC_W-1:0] a_frac, b_frac;
  sfm_digit_t [NDIG-1:0] dig_d;

  sfm_operand_fmt #(.BUS_W(BUS_W), .FRAC_W(FRAC_W), .HALF_W(HALF_W), .LANE_W(LANE_W))
    u_fmt_a (.bus_i(op_a), .pk_i(pack_mode), .frac_o(a_frac));

  sfm_operand_fmt #(.BUS_W(BUS_W), .FRAC_W(FRAC_W), .HALF_W(HALF_W), .LANE_W(LANE_W))
    u_fmt_b (.bus_i(op_b), .pk_i(pack_mode), .frac_o(b_frac));

  sfm_booth_recode #(.FRAC_W(FRAC_W), .NDIG(NDIG))
    u_recode (.mult_i(b_frac), .dig_o(dig_d));

  // ---------------- stage 1 registers ----------------
  logic                  v1_q, v1_d;
  logic [FRAC_W-1:0]     a1_q, a1_d;
  sfm_digit_t [NDIG-1:0] dig1_q, dig1_d;
  logic                  pk1_q, pk1_d;
  logic                  ld1;

  assign ld1 = in_valid;

  always_comb begin
    v1_d   = in_valid;
    a1_d   = ld1 ? a_frac    : a1_q;
    dig1_d = ld1 ? dig_d     : dig1_q;
    pk1_d  = ld1 ? pack_mode : pk1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= v1_d;
  end

  always_ff @(posedge clk) begin
    a1_q   <= a1_d;
    dig1_q <= dig1_d;
    pk1_q  <= pk1_d;
  end

  // ---------------- partial products and compression ----------------
  logic [NROW-1:0][PROD_W-1:0] rows;

  sfm_ppgen #(.FRAC_W(FRAC_W), .HALF_W(HALF_W), .NDIG(NDIG), .PROD_W(PROD_W), .NROW(NROW))
    u_ppgen (.mcand_i(a1_q), .dig_i(dig1_q), .pk_i(pk1_q), .rows_o(rows));

  logic [PROD_W-1:0] ps [NCSA];
  logic [PROD_W-1:0] pc [NCSA];

  for (genvar k = 0; k < NCSA; k++) begin : g_csa
    if (k == 0) begin : g_first
      sfm_csa3 #(.W(PROD_W)) u_csa (
        .x_i(rows[0]), .y_i(rows[1]), .z_i(rows[2]),
        .s_o(ps[k]),   .c_o(pc[k]));
    end else begin : g_next
      sfm_csa3 #(.W(PROD_W)) u_csa (
        .x_i(ps[k-1]), .y_i(pc[k-1]), .z_i(rows[k+2]),
        .s_o(ps[k]),   .c_o(pc[k]));
    end
  end

  // ---------------- stage 2 registers ----------------
  logic              v2_q, v2_d;
  logic [PROD_W-1:0] sum_q, sum_d, car_q, car_d;
  logic              ld2;

  assign ld2 = v1_q;

  always_comb begin
    v2_d  = v1_q;
    sum_d = ld2 ? ps[NCSA-1] : sum_q;
    car_d = ld2 ? pc[NCSA-1] : car_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2_q <= 1'b0;
    else        v2_q <= v2_d;
  end

  always_ff @(posedge clk) begin
    sum_q <= sum_d;
    car_q <= car_d;
  end

  assign out_valid = v2_q;
  assign sum_o     = sum_q;
  assign carry_o   = car_q;

endmodule

// File: rtl/sfm_chk.sv
module sfm_chk #(
  parameter int BUS_W  = 64,
  parameter int FRAC_W = 56,
  parameter int HALF_W = 32,
  parameter int LANE_W = 24,
  parameter int PROD_W = 2*FRAC_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              pack_mode,
  input logic [BUS_W-1:0]  op_a,
  input logic [BUS_W-1:0]  op_b,
  input logic              out_valid,
  input logic [PROD_W-1:0] sum_o,
  input logic [PROD_W-1:0] carry_o
);

  localparam logic [BUS_W-1:0] LMASK = {{(BUS_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
  localparam logic [BUS_W-1:0] WMASK = {{(BUS_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};

  function automatic logic [PROD_W-1:0] ref_prod(logic [BUS_W-1:0] a,
                                                  logic [BUS_W-1:0] b,
                                                  logic pk);
    logic [PROD_W-1:0] hi, lo;
    if (!pk) return PROD_W'(a & WMASK) * PROD_W'(b & WMASK);
    hi = PROD_W'((a >> HALF_W) & LMASK) * PROD_W'((b >> HALF_W) & LMASK);
    lo = PROD_W'(a & LMASK) * PROD_W'(b & LMASK);
    return (hi << (2*HALF_W)) + lo;
  endfunction

  logic [PROD_W-1:0] res;
  assign res = sum_o + carry_o;

  // R1 R2 R6
  prod_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> res == ref_prod($past(op_a, 2), $past(op_b, 2), $past(pack_mode, 2)));

  // R4
  top_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> res[PROD_W-1:2*FRAC_W] == '0);

  // R3
  lane_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(pack_mode, 2)) |-> res[2*HALF_W-1:2*LANE_W] == '0);

  // R5
  lat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R5
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

endmodule

bind simd_frac_mul sfm_chk #(
  .BUS_W(BUS_W), .FRAC_W(FRAC_W), .HALF_W(HALF_W), .LANE_W(LANE_W), .PROD_W(PROD_W)
) u_sfm_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pack_mode(pack_mode),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .sum_o(sum_o), .carry_o(carry_o)
);

// File: tb/simd_frac_mul_test.sv
module simd_frac_mul_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         pack_mode = 1'b0;
  logic [63:0]  op_a = '0;
  logic [63:0]  op_b = '0;
  logic         out_valid;
  logic [115:0] sum_o, carry_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  simd_frac_mul uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pack_mode(pack_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .sum_o(sum_o), .carry_o(carry_o)
  );

  function automatic logic [115:0] model(logic [63:0] a, logic [63:0] b, logic pk);
    logic [115:0] hi, lo;
    if (!pk) return 116'(a[55:0]) * 116'(b[55:0]);
    hi = 116'(a[55:32]) * 116'(b[55:32]);
    lo = 116'(a[23:0]) * 116'(b[23:0]);
    return (hi << 64) + lo;
  endfunction

  function automatic logic [115:0] resolved();
    return sum_o + carry_o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [115:0] act,
                       input logic [115:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one isolated operation, checking latency, value and hold
  task automatic t_single(input logic [63:0] a, input logic [63:0] b, input logic pk,
                          input string req);
    logic [115:0] exp, held;
    exp = model(a, b, pk);
    @(negedge clk);
    op_a = a; op_b = b; pack_mode = pk; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; op_a = ~a; op_b = ~b; pack_mode = ~pk;
    check(out_valid == 1'b0, "R5 early", 116'(out_valid), 116'(0));
    @(negedge clk);
    check(out_valid == 1'b1, "R5 valid", 116'(out_valid), 116'(1));
    check(resolved() == exp, req, resolved(), exp);
    held = resolved();
    @(negedge clk);
    check(out_valid == 1'b0 && resolved() == held, "R8 hold", resolved(), held);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 in reset", 116'(out_valid), 116'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 after release", 116'(out_valid), 116'(0));
  endtask

  task automatic t_wide_corners();
    t_single(64'h0, 64'h0, 1'b0, "R1 zero");
    t_single(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R1 all ones, top byte ignored");
    t_single(64'h0080_0000_0000_0000, 64'h0080_0000_0000_0000, 1'b0, "R1 implicit bit only");
    t_single(64'h0010_0000_0000_0000, 64'h001F_FFFF_FFFF_FFFF, 1'b0, "R1 double implicit");
    t_single(64'hAB55_5555_5555_5555, 64'h7EAA_AAAA_AAAA_AAAA, 1'b0, "R1 alternating");
  endtask

  task automatic t_packed_lanes(input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [115:0] r, lo, hi;
    t_single(a, b, 1'b1, {"R2 ", tag});
    r  = resolved();
    lo = 116'(a[23:0]) * 116'(b[23:0]);
    hi = 116'(a[55:32]) * 116'(b[55:32]);
    check(116'(r[47:0]) == lo, {"R3 lower lane ", tag}, 116'(r[47:0]), lo);
    check(116'(r[111:64]) == hi, {"R3 upper lane ", tag}, 116'(r[111:64]), hi);
    check(r[63:48] == '0, {"R3 gap ", tag}, 116'(r[63:48]), 116'(0));
    check(r[115:112] == '0, {"R4 top ", tag}, 116'(r[115:112]), 116'(0));
  endtask

  task automatic t_packed_corners();
    t_packed_lanes(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "all ones");
    t_packed_lanes(64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "zero");
    t_packed_lanes(64'h0080_0000_0080_0000, 64'h0080_0000_0080_0000, "implicit only");
    t_packed_lanes(64'hC0FF_FFFF_4000_0000, 64'h3F80_0001_BFFF_FFFF, "mixed");
  endtask

  // back-to-back issue with the mode toggling
  task automatic t_stream();
    localparam int N = 16;
    logic [115:0] exp [N];
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(out_valid == 1'b1, "R6 stream valid", 116'(out_valid), 116'(1));
        check(resolved() == exp[i-2], "R6 stream value", resolved(), exp[i-2]);
      end
      if (i < N) begin
        op_a = {$urandom, $urandom};
        op_b = {$urandom, $urandom};
        pack_mode = i[0];
        exp[i] = model(op_a, op_b, pack_mode);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R5 stream drain", 116'(out_valid), 116'(0));
  endtask

  task automatic t_random();
    for (int i = 0; i < 30; i++) begin
      t_single({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "R1 random");
      t_packed_lanes({$urandom, $urandom}, {$urandom, $urandom}, "random");
    end
  endtask

  initial begin
    t_reset();
    t_wide_corners();
    t_packed_corners();
    t_stream();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule